// File: doc/BRIEF.md
# Nibble-Serial Sample Transceiver

This block carries 16-bit samples in both directions over 4-bit data buses. A free-running slot counter splits time into words of four master-clock cycles, so a complete sample moves once every four cycles. It also produces a word clock at one quarter of the master clock, high for the first half of each word. In the transmit direction the block takes one nibble per cycle from the serial input bus and builds a parallel word, least significant nibble first. It presents each finished word for one cycle. In the receive direction it accepts a parallel word once per word period and sends it out one nibble per cycle, least significant nibble first.

The parallel receive input uses a valid/ready handshake. `rx_ready` is high only in the last slot of a word, and a word moves when `rx_in_valid` and `rx_ready` are both high at a clock edge. A producer may hold `rx_in_valid` for as long as it likes; back-pressure only means waiting for the next last slot. If no word moves in that slot, the previous word is sent again. The transmit parallel output runs at a fixed rate and cannot be stalled. `tx_word_valid` is a one-cycle pulse, so the consumer must take the word in the cycle the pulse is high. The word stays readable until the next pulse.

Top module: `nibble_xcvr`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `slot` is 0, `word_clk` is 1, `tx_word_valid` is 0, `tx_word` is 0, `rx_ready` is 0 and `rx_nib` is 0.
- R2: `slot` counts 0, 1, 2, 3 and wraps to 0, advancing by one every clock. `word_clk` is 1 in slots 0 and 1 and 0 in slots 2 and 3.
- R3: The nibble sampled from `tx_nib` in slot k lands in `tx_word` bits [4k+3:4k], so the first nibble of a word is its least significant.
- R4: `tx_word_valid` is high for exactly one cycle, in the slot 0 that follows the capture of slot 3, and never at any other time. `tx_word` changes only when that pulse appears.
- R5: `rx_ready` is 1 exactly when `slot` is 3.
- R6: A word accepted in slot 3 appears on `rx_nib` over the next four cycles (slots 0 to 3) as bits [3:0], [7:4], [11:8], [15:12] in that order.
- R7: `rx_in_valid` and `rx_in_word` have no effect in slots 0 to 2. When no word is accepted in slot 3, the previous word is repeated on `rx_nib`.
- R8: Until the first word is accepted after reset, `rx_nib` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; every nibble moves on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slot | output | 2 | Current nibble slot within the word |
| word_clk | output | 1 | Word clock at a quarter of the master clock; high in slots 0 and 1 |
| tx_nib | input | 4 | Serial transmit nibble, sampled every clock |
| tx_word | output | 16 | Last assembled transmit word |
| tx_word_valid | output | 1 | One-cycle pulse marking a new `tx_word` |
| rx_in_word | input | 16 | Parallel receive word from the producer |
| rx_in_valid | input | 1 | Producer has a word on `rx_in_word` |
| rx_ready | output | 1 | Block takes a word at this edge (slot 3 only) |
| rx_nib | output | 4 | Serial receive nibble |

## Verification
The assertions assume that the producer's `rx_in_word` is stable around the clock edge at which a handshake completes. They also assume that `tx_nib` is a defined value at every edge, because the transmit lane has no qualifier and is taken whatever its value. The bench changes all inputs on the falling edge only, and draws every value from a defined random or fixed pattern. It also runs phases in which `rx_in_valid` is raised only outside slot 3, so the ignored offers are exercised without breaking those assumptions.

// File: rtl/nx_pkg.sv
package nx_pkg;
  localparam int NX_NIB_W = 4;
  localparam int NX_NIBS  = 4;
endpackage

// File: rtl/nx_slot_ctr.sv
module nx_slot_ctr #(
  parameter int NIBS = nx_pkg::NX_NIBS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [$clog2(NIBS)-1:0] slot,
  output logic                    last
);
  localparam int SW = $clog2(NIBS);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NIBS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)            slot <= '0;
    else if (slot == LAST_SLOT) slot <= '0;
    else                   slot <= slot + 1'b1;
  end

  assign last = (slot == LAST_SLOT);
endmodule

// File: rtl/nx_tx_pack.sv
module nx_tx_pack #(
  parameter int NIB_W = nx_pkg::NX_NIB_W,
  parameter int NIBS  = nx_pkg::NX_NIBS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NIBS)-1:0] slot,
  input  logic                    last,
  input  logic [NIB_W-1:0]        nib,
  output logic [NIB_W*NIBS-1:0]   word,
  output logic                    valid
);
  localparam int SW = $clog2(NIBS);
  localparam int WW = NIB_W * NIBS;

  logic [NIB_W-1:0] lane [NIBS-1];
  logic [WW-1:0]    next_word;

  // one holding register per lower lane, loaded in its own slot
  for (genvar k = 0; k < NIBS - 1; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                 lane[k] <= '0;
      else if (slot == SW'(k))    lane[k] <= nib;
    end
    assign next_word[k*NIB_W +: NIB_W] = lane[k];
  end
  // top lane bypasses storage: it is taken straight off the bus
  assign next_word[WW-1 -: NIB_W] = nib;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= last;
      if (last) word <= next_word;
    end
  end
endmodule

// File: rtl/nx_rx_unpack.sv
module nx_rx_unpack #(
  parameter int NIB_W = nx_pkg::NX_NIB_W,
  parameter int NIBS  = nx_pkg::NX_NIBS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NIBS)-1:0] slot,
  input  logic                    last,
  input  logic [NIB_W*NIBS-1:0]   in_word,
  input  logic                    in_valid,
  output logic                    ready,
  output logic [NIB_W-1:0]        nib
);
  localparam int WW = NIB_W * NIBS;

  logic [WW-1:0]    hold;
  logic [NIB_W-1:0] lanes [NIBS];

  assign ready = last;

  always_ff @(posedge clk) begin
    if (!rst_n)                hold <= '0;
    else if (ready && in_valid) hold <= in_word;
  end

  for (genvar k = 0; k < NIBS; k++) begin : g_out
    assign lanes[k] = hold[k*NIB_W +: NIB_W];
  end

  assign nib = lanes[slot];
endmodule

// File: rtl/nibble_xcvr.sv
module nibble_xcvr #(
  parameter int NIB_W = nx_pkg::NX_NIB_W,
  parameter int NIBS  = nx_pkg::NX_NIBS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [$clog2(NIBS)-1:0] slot,
  output logic                    word_clk,
  input  logic [NIB_W-1:0]        tx_nib,
  output logic [NIB_W*NIBS-1:0]   tx_word,
  output logic                    tx_word_valid,
  input  logic [NIB_W*NIBS-1:0]   rx_in_word,
  input  logic                    rx_in_valid,
  output logic                    rx_ready,
  output logic [NIB_W-1:0]        rx_nib
);
  logic last;

  nx_slot_ctr #(.NIBS(NIBS)) u_slot (
    .clk(clk), .rst_n(rst_n), .slot(slot), .last(last)
  );

  nx_tx_pack #(.NIB_W(NIB_W), .NIBS(NIBS)) u_tx (
    .clk(clk), .rst_n(rst_n), .slot(slot), .last(last),
    .nib(tx_nib), .word(tx_word), .valid(tx_word_valid)
  );

  nx_rx_unpack #(.NIB_W(NIB_W), .NIBS(NIBS)) u_rx (
    .clk(clk), .rst_n(rst_n), .slot(slot), .last(last),
    .in_word(rx_in_word), .in_valid(rx_in_valid),
    .ready(rx_ready), .nib(rx_nib)
  );

  assign word_clk = (int'(slot) < NIBS / 2);
endmodule

// File: rtl/nx_xcvr_chk.sv
module nx_xcvr_chk #(
  parameter int NIB_W = nx_pkg::NX_NIB_W,
  parameter int NIBS  = nx_pkg::NX_NIBS
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [$clog2(NIBS)-1:0] slot,
  input logic                    word_clk,
  input logic [NIB_W-1:0]        tx_nib,
  input logic [NIB_W*NIBS-1:0]   tx_word,
  input logic                    tx_word_valid,
  input logic [NIB_W*NIBS-1:0]   rx_in_word,
  input logic                    rx_in_valid,
  input logic                    rx_ready,
  input logic [NIB_W-1:0]        rx_nib
);
  localparam int SW = $clog2(NIBS);
  localparam int WW = NIB_W * NIBS;
  localparam logic [SW-1:0] LAST_SLOT = SW'(NIBS - 1);

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> slot == (($past(slot) == LAST_SLOT) ? '0 : $past(slot) + 1'b1));

  p_word_clk_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_clk) |-> slot == '0);

  p_tx_top_nib_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word_valid |-> tx_word[WW-1 -: NIB_W] == $past(tx_nib));

  p_valid_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word_valid |-> slot == '0);

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word_valid |=> !tx_word_valid);

  p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_word_valid |-> $stable(tx_word));

  p_ready_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> slot == LAST_SLOT);

  p_rx_first_nib_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == '0 && $past(rx_in_valid && rx_ready)) |-> rx_nib == $past(rx_in_word[NIB_W-1:0]));

  p_rx_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == '0 && !$past(rx_in_valid && rx_ready) && $past(rst_n)) |-> rx_nib == $past(rx_nib, NIBS));
endmodule

bind nibble_xcvr nx_xcvr_chk #(.NIB_W(NIB_W), .NIBS(NIBS)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot(slot), .word_clk(word_clk),
  .tx_nib(tx_nib), .tx_word(tx_word), .tx_word_valid(tx_word_valid),
  .rx_in_word(rx_in_word), .rx_in_valid(rx_in_valid),
  .rx_ready(rx_ready), .rx_nib(rx_nib)
);

// File: tb/test_nibble_xcvr.sv
module test_nibble_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  slot;
  logic        word_clk;
  logic [3:0]  tx_nib = '0;
  logic [15:0] tx_word;
  logic        tx_word_valid;
  logic [15:0] rx_in_word = '0;
  logic        rx_in_valid = 1'b0;
  logic        rx_ready;
  logic [3:0]  rx_nib;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  string rx_tag = "R8";

  // behavioural model state
  int          m_slot = 0;
  bit          m_txv = 0;
  logic [15:0] m_txw = '0;
  logic [15:0] m_hold = '0;
  logic [3:0]  nq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_xcvr i_nibble_xcvr (
    .clk(clk), .rst_n(rst_n), .slot(slot), .word_clk(word_clk),
    .tx_nib(tx_nib), .tx_word(tx_word), .tx_word_valid(tx_word_valid),
    .rx_in_word(rx_in_word), .rx_in_valid(rx_in_valid),
    .rx_ready(rx_ready), .rx_nib(rx_nib)
  );

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_slot = 0; m_txv = 0; m_txw = '0; m_hold = '0; nq.delete();
    end else begin
      nq.push_back(tx_nib);
      m_txv = 0;
      if (m_slot == 3) begin
        m_txw = {nq[3], nq[2], nq[1], nq[0]};
        nq.delete();
        m_txv = 1;
        if (rx_in_valid) m_hold = rx_in_word;
      end
      m_slot = (m_slot + 1) % 4;
    end
  end

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic compare_all(bit in_reset);
    logic [15:0] exp_nib;
    exp_nib = 16'((m_hold >> (4 * m_slot)) & 16'hF);
    if (in_reset) begin
      chk("R1", "slot", 16'(slot), 16'd0);
      chk("R1", "word_clk", 16'(word_clk), 16'd1);
      chk("R1", "tx_word_valid", 16'(tx_word_valid), 16'd0);
      chk("R1", "tx_word", tx_word, 16'd0);
      chk("R1", "rx_ready", 16'(rx_ready), 16'd0);
      chk("R1", "rx_nib", 16'(rx_nib), 16'd0);
    end else begin
      chk("R2", "slot", 16'(slot), 16'(m_slot));
      chk("R2", "word_clk", 16'(word_clk), 16'(m_slot < 2));
      chk("R4", "tx_word_valid", 16'(tx_word_valid), 16'(m_txv));
      chk("R3", "tx_word", tx_word, m_txw);
      chk("R5", "rx_ready", 16'(rx_ready), 16'(m_slot == 3));
      chk(rx_tag, "rx_nib", 16'(rx_nib), exp_nib);
    end
  endtask

  task automatic step(bit in_reset);
    @(negedge clk);
    compare_all(in_reset);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1);
    rst_n = 1'b1;
    // R8: idle receive side, random transmit nibbles
    rx_tag = "R8";
    for (int i = 0; i < 12; i++) begin
      tx_nib = 4'($urandom);
      step(0);
    end
    // R6: producer always valid with fresh words
    rx_tag = "R6";
    for (int i = 0; i < 48; i++) begin
      tx_nib = 4'($urandom);
      rx_in_valid = 1'b1;
      rx_in_word = 16'($urandom);
      step(0);
    end
    // R7: offers only outside slot 3, so they must be ignored
    rx_tag = "R7";
    for (int i = 0; i < 48; i++) begin
      tx_nib = 4'($urandom);
      rx_in_word = 16'($urandom);
      rx_in_valid = (m_slot != 3);
      step(0);
    end
    // R3 corner patterns on transmit lanes, receive random
    rx_tag = "R6";
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 8; i++) begin
        case (p)
          0: tx_nib = 4'hF;
          1: tx_nib = 4'h0;
          default: tx_nib = (m_slot == 0 || m_slot == 3) ? 4'h8 : 4'h1;
        endcase
        rx_in_valid = 1'($urandom);
        rx_in_word = (p == 0) ? 16'hFFFF : 16'h8001;
        step(0);
      end
    end
    // mixed random traffic
    rx_tag = "R7";
    for (int i = 0; i < 400; i++) begin
      tx_nib = 4'($urandom);
      rx_in_valid = 1'($urandom);
      rx_in_word = 16'($urandom);
      step(0);
    end
    // R1: reset in mid-stream, then recheck R8 behaviour
    rst_n = 1'b0;
    step(0);
    for (int i = 0; i < 2; i++) step(1);
    rst_n = 1'b1;
    rx_in_valid = 1'b0;
    rx_tag = "R8";
    for (int i = 0; i < 8; i++) begin
      tx_nib = 4'($urandom);
      step(0);
    end
    done = 1;
    finish_run();
  end
endmodule